// File: doc/BRIEF.md
# Clock-Calendar Two-Wire Register Port with Time Snapshot

This block is the serial register port of a clock-calendar device. It listens on a two-wire I2C bus as a slave and oversamples SCL and SDA with the system clock. It gives the bus access to a 64-byte space. Locations 00h–06h hold time and date, location 07h holds control, and locations 08h–3Fh are 56 bytes of general-purpose RAM held inside the block. The open-drain data line is modelled as a single drive-low enable.

The time and control bytes belong to timekeeping logic outside this block. They arrive on a flat input vector. At every START, including a repeated START, the block freezes a copy of them, and all bus reads of 00h–07h are served from that copy. The outside logic can therefore keep counting during a multi-byte read, and the master still gets one coherent moment in time. Bus writes to 00h–07h leave the block as a one-cycle write strobe with address and data. Bus writes to 08h–3Fh land in the internal RAM. Every write commits at the start of the acknowledge clock.

Top module: `tk_i2c_regfile`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block releases SDA, and it acknowledges no byte until the next START.
- R2: Every START, including a repeated START, copies the eight bytes of `live_time` into a snapshot. Reads of addresses 00h–07h return snapshot bytes, even if `live_time` changes during the read.
- R3: The block acknowledges only the device address 1101000, where bit 0 of the first byte is 0 for write and 1 for read. For any other address it does not acknowledge, and it ignores the bus until the next START, so no write takes effect.
- R4: In a write, the first byte after the address is the register pointer, and only its bits 5:0 are used. Each following byte commits when its acknowledge begins. For pointer 00h–07h this is a one-cycle `wr_valid` pulse carrying `wr_addr` = pointer[2:0] and `wr_data`. For pointer 08h–3Fh the byte is stored in the internal RAM.
- R5: For each byte it accepts, the block holds SDA low for the whole high phase of the ninth SCL clock. In reads it drives data MSB first, and it changes SDA only while SCL is low.
- R6: The pointer advances by one after every byte written or sent, so a read continues at the next address. When the master does not acknowledge a sent byte, the block releases SDA and drives no more bits.
- R7: The pointer wraps from 3Fh to 00h.
- R8: During and after reset, `sda_drive_low` and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| live_time | input | 64 | Live time and control bytes; byte i is bits 8i+7:8i |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_valid | output | 1 | One-cycle strobe for a bus write to 00h–07h |
| wr_addr | output | 3 | Target time/control register of the strobe |
| wr_data | output | 8 | Data written with the strobe |

## Verification
Some behaviour is checked by assertions on every cycle. The snapshot equals the live bytes after each START and stays unchanged between STARTs. SDA is released after a STOP. Every write strobe coincides with an acknowledge. The SDA drive changes only while SCL is low, apart from a START or STOP. Other behaviour only the bench scenarios can show: address matching, pointer loading and wrap-around, RAM contents surviving a rejected transfer, coherent reads while the live bytes move, and the block going silent after a master NACK.

// File: rtl/tk_i2c_pkg.sv
package tk_i2c_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_RACK
    } bus_state_t;

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    // Byte idx of a flat little-endian byte vector
    function automatic byte_t pick_byte(input logic [63:0] flat, input int idx);
        return flat[8*idx +: 8];
    endfunction

endpackage

// File: rtl/tk_i2c_sync.sv
module tk_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Idle bus level is high, so the chain resets to 1
    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tk_i2c_snapshot.sv
module tk_i2c_snapshot #(
    parameter int N_TIME = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  logic [8*N_TIME-1:0]   live,
    output logic [8*N_TIME-1:0]   snap
);
    for (genvar g = 0; g < N_TIME; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)          snap[8*g +: 8] <= '0;
            else if (capture) snap[8*g +: 8] <= live[8*g +: 8];
        end
    end
endmodule

// File: rtl/tk_i2c_ram.sv
module tk_i2c_ram #(
    parameter int AW    = 6,
    parameter int DEPTH = 56
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/tk_i2c_regfile.sv
module tk_i2c_regfile
    import tk_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         ADDR_W      = 6,
    parameter int         N_TIME      = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        TIME_AW     = $clog2(N_TIME)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic [8*N_TIME-1:0]  live_time,
    output logic                 sda_drive_low,
    output logic                 wr_valid,
    output logic [TIME_AW-1:0]   wr_addr,
    output logic [7:0]           wr_data
);
    localparam int               RAM_DEPTH = (1 << ADDR_W) - N_TIME;
    localparam logic [ADDR_W-1:0] TIME_END = N_TIME[ADDR_W-1:0];

    // Line sampling and condition detection
    logic scl_s, sda_s, scl_q, sda_q;

    tk_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
    tk_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

    // Snapshot of the live time bytes
    logic [8*N_TIME-1:0] snap;
    tk_i2c_snapshot #(.N_TIME(N_TIME)) u_snap (
        .clk(clk), .rst(rst), .capture(start_det), .live(live_time), .snap(snap)
    );

    // General RAM above the time registers
    bus_state_t        st, nxt;
    logic [3:0]        cnt;
    byte_t             sh, tx;
    logic [ADDR_W-1:0] ptr;
    logic              mack;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    byte_t             ram_wdata, ram_rdata, rd_byte;
    logic [ADDR_W-1:0] ram_raddr;

    assign ram_raddr = ptr - TIME_END;

    tk_i2c_ram #(.AW(ADDR_W), .DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    assign rd_byte = (ptr < TIME_END) ? snap[8*ptr[TIME_AW-1:0] +: 8] : ram_rdata;

    // Byte-level protocol engine
    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            nxt           <= ST_IDLE;
            cnt           <= '0;
            sh            <= '0;
            tx            <= '0;
            ptr           <= '0;
            mack          <= 1'b0;
            sda_drive_low <= 1'b0;
            wr_valid      <= 1'b0;
            wr_addr       <= '0;
            wr_data       <= '0;
            ram_we        <= 1'b0;
            ram_waddr     <= '0;
            ram_wdata     <= '0;
        end else begin
            wr_valid <= 1'b0;
            ram_we   <= 1'b0;
            if (start_det) begin
                st            <= ST_DEV;
                cnt           <= '0;
                sda_drive_low <= 1'b0;
            end else if (stop_det) begin
                st            <= ST_IDLE;
                sda_drive_low <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_PTR, ST_WR: begin
                        if (scl_rise && cnt < BITS_PER_BYTE) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end
                        if (scl_fall && cnt == BITS_PER_BYTE) begin
                            cnt <= '0;
                            if (st == ST_DEV) begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    sda_drive_low <= 1'b1;
                                    st            <= ST_ACK;
                                    nxt           <= sh[0] ? ST_RD : ST_PTR;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_PTR) begin
                                ptr           <= sh[ADDR_W-1:0];
                                sda_drive_low <= 1'b1;
                                st            <= ST_ACK;
                                nxt           <= ST_WR;
                            end else begin
                                if (ptr < TIME_END) begin
                                    wr_valid <= 1'b1;
                                    wr_addr  <= ptr[TIME_AW-1:0];
                                    wr_data  <= sh;
                                end else begin
                                    ram_we    <= 1'b1;
                                    ram_waddr <= ptr - TIME_END;
                                    ram_wdata <= sh;
                                end
                                ptr           <= ptr + 1'b1;
                                sda_drive_low <= 1'b1;
                                st            <= ST_ACK;
                                nxt           <= ST_WR;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (nxt == ST_RD) begin
                                tx            <= rd_byte;
                                sda_drive_low <= ~rd_byte[7];
                                cnt           <= 4'd1;
                            end else begin
                                sda_drive_low <= 1'b0;
                                cnt           <= '0;
                            end
                            st <= nxt;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == BITS_PER_BYTE) begin
                                sda_drive_low <= 1'b0;
                                ptr           <= ptr + 1'b1;
                                mack          <= 1'b0;
                                st            <= ST_RACK;
                            end else begin
                                sda_drive_low <= ~tx[6];
                                tx            <= {tx[6:0], 1'b0};
                                cnt           <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                tx            <= rd_byte;
                                sda_drive_low <= ~rd_byte[7];
                                cnt           <= 4'd1;
                                st            <= ST_RD;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tk_i2c_checker.sv
module tk_i2c_checker #(
    parameter int N_TIME = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                scl_s,
    input logic                start_det,
    input logic                stop_det,
    input logic                sda_drive_low,
    input logic                wr_valid,
    input logic [8*N_TIME-1:0] live_time,
    input logic [8*N_TIME-1:0] snap
);
    assert_snap_capture_R2: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (snap == $past(live_time)))
        else $error("snapshot differs from live bytes after START");

    assert_snap_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !start_det |=> $stable(snap))
        else $error("snapshot moved without START");

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_drive_low)
        else $error("SDA still driven after STOP");

    assert_commit_with_ack_R4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> sda_drive_low)
        else $error("write strobe outside acknowledge");

    assert_sda_change_low_R5: assert property (@(posedge clk) disable iff (rst)
        ((sda_drive_low != $past(sda_drive_low)) && !$past(start_det) && !$past(stop_det))
            |-> !$past(scl_s))
        else $error("SDA drive changed while SCL high");

    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> (!sda_drive_low && !wr_valid))
        else $error("outputs active out of reset");
endmodule

bind tk_i2c_regfile tk_i2c_checker #(.N_TIME(N_TIME)) chk_i (
    .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
    .sda_drive_low(sda_drive_low), .wr_valid(wr_valid), .live_time(live_time), .snap(snap)
);

// File: tb/tk_i2c_regfile_tb_top.sv
module tk_i2c_regfile_tb_top;
    localparam int H = 20;               // SCL half period in system clocks
    localparam logic [7:0] AW = 8'hD0;   // address + write
    localparam logic [7:0] AR = 8'hD1;   // address + read

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [63:0] live_time = 64'h0;
    logic sda_drive_low, wr_valid, sda_bus;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_drive_low;

    tk_i2c_regfile dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .live_time(live_time),
        .sda_drive_low(sda_drive_low), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int n_chk = 0, n_bad = 0, wn = 0;
    logic [2:0] wlog_a [16];
    logic [7:0] wlog_d [16];
    bit done = 0;

    always @(posedge clk) begin
        if (wr_valid && wn < 16) begin
            wlog_a[wn] <= wr_addr;
            wlog_d[wn] <= wr_data;
            wn <= wn + 1;
        end
    end

    // {pointer, data} pairs for RAM write/read-back
    localparam logic [13:0] VEC [8] = '{
        {6'h08, 8'hA5}, {6'h09, 8'h3C}, {6'h15, 8'hFF}, {6'h20, 8'h00},
        {6'h2A, 8'h81}, {6'h30, 8'h7E}, {6'h3E, 8'h5A}, {6'h0F, 8'hC3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(H);
            scl_m = 1'b1; hold(H);
            scl_m = 1'b0; hold(4);
        end
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(4);
        s1 = sda_bus; hold(H - 4);
        s2 = sda_bus;
        scl_m = 1'b0; hold(4);
        ack = !s1 && !s2;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold(H);
            scl_m = 1'b1; hold(H / 2);
            b[i] = sda_bus; hold(H / 2);
            scl_m = 1'b0; hold(4);
        end
        sda_m = ~give_ack; hold(H);
        scl_m = 1'b1; hold(H);
        scl_m = 1'b0; hold(4);
        sda_m = 1'b1;
    endtask

    task automatic begin_write(input logic [7:0] p, input string req);
        logic a;
        i2c_start();
        send_byte(AW, a); chk({req, " address ack (R5)"}, a, 1);
        send_byte(p, a);  chk({req, " pointer ack (R5)"}, a, 1);
    endtask

    task automatic read_one(input logic [7:0] p, output logic [7:0] b, input string req);
        logic a;
        begin_write(p, req);
        i2c_start();
        send_byte(AR, a); chk({req, " read address ack (R5)"}, a, 1);
        read_byte(1'b0, b);
        i2c_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        logic [63:0] pat_a, pat_b;
        int w0;

        hold(5);
        chk("R8 reset sda_drive_low", sda_drive_low, 0);
        chk("R8 reset wr_valid", wr_valid, 0);
        rst = 1'b0;
        hold(5);
        chk("R8 after reset sda_drive_low", sda_drive_low, 0);

        // R4 RAM writes and read-back, MSB first (R5)
        for (int i = 0; i < 8; i++) begin
            begin_write({2'b00, VEC[i][13:8]}, "R4");
            send_byte(VEC[i][7:0], a); chk("R4 data ack", a, 1);
            i2c_stop();
        end
        for (int i = 0; i < 8; i++) begin
            read_one({2'b00, VEC[i][13:8]}, b, "R4");
            chk("R4 RAM read-back", b, VEC[i][7:0]);
        end

        // R3 foreign address: no ack, rest ignored
        w0 = wn;
        i2c_start();
        send_byte(8'hA0, a); chk("R3 foreign address not acked", a, 0);
        send_byte(8'h08, a); chk("R3 ignored byte not acked", a, 0);
        send_byte(8'h99, a);
        i2c_stop();
        hold(4);
        chk("R3 no write strobe", wn, w0);
        read_one(8'h08, b, "R3");
        chk("R3 RAM unchanged", b, 8'hA5);

        // R1 byte without START after STOP is not acked
        send_byte(AW, a); chk("R1 no ack without START", a, 0);
        i2c_stop();
        chk("R1 SDA released after STOP", sda_drive_low, 0);

        // R4 time register writes via strobe; upper pointer bits ignored
        w0 = wn;
        begin_write(8'hC2, "R4");
        send_byte(8'h45, a); chk("R4 time write ack", a, 1);
        send_byte(8'h17, a); chk("R4 time write ack", a, 1);
        i2c_stop();
        chk("R4 two strobes", wn - w0, 2);
        chk("R4 first strobe addr", wlog_a[w0], 3'd2);
        chk("R4 first strobe data", wlog_d[w0], 8'h45);
        chk("R4 second strobe addr", wlog_a[w0 + 1], 3'd3);
        chk("R4 second strobe data", wlog_d[w0 + 1], 8'h17);

        // R7 pointer wrap 3Fh -> 00h
        w0 = wn;
        begin_write(8'h3F, "R7");
        send_byte(8'h6B, a); chk("R7 ack at 3F", a, 1);
        send_byte(8'h33, a); chk("R7 ack after wrap", a, 1);
        i2c_stop();
        chk("R7 one strobe", wn - w0, 1);
        chk("R7 strobe addr after wrap", wlog_a[w0], 3'd0);
        chk("R7 strobe data after wrap", wlog_d[w0], 8'h33);
        read_one(8'h3F, b, "R7");
        chk("R7 RAM at 3F", b, 8'h6B);

        // R2 snapshot on repeated START, live bytes move during read; R6 sequential read
        pat_a = 64'h8877665544332211;
        pat_b = 64'h0FEEDDCCBBAA9901;
        live_time = pat_a;
        begin_write(8'h00, "R2");
        i2c_start();
        live_time = pat_b;
        send_byte(AR, a); chk("R2 read address ack", a, 1);
        for (int i = 0; i < 8; i++) begin
            read_byte(i != 7, b);
            chk("R2 R6 snapshot byte sequential read", b, pat_a[8*i +: 8]);
        end
        // R6 after NACK the slave stays silent for another clock
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H / 2);
        chk("R6 SDA released after NACK", sda_bus, 1);
        hold(H / 2);
        scl_m = 1'b0; hold(4);
        i2c_stop();
        // R6 read continues at 08h after wrapping the time bytes
        i2c_start();
        send_byte(AR, a); chk("R6 current-address read ack", a, 1);
        read_byte(1'b0, b);
        i2c_stop();
        chk("R6 pointer advanced to 08h", b, 8'hA5);
        // R2 new START takes fresh snapshot
        read_one(8'h00, b, "R2");
        chk("R2 fresh snapshot byte 0", b, pat_b[7:0]);
        read_one(8'h07, b, "R2");
        chk("R2 fresh snapshot byte 7", b, pat_b[63:56]);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule